// File: doc/BRIEF.md
# Stochastic Update Pulse Generator

This block drives the periphery of a resistive cross-point array during an outer-product weight update. It takes a signed column vector (the activations, one element per column lane) and a signed row vector (the errors, one element per row lane). It then issues a programmable number of time slots. In each slot, every lane raises a pulse with a probability equal to its element magnitude times a gain. A device in the array changes only when its column pulse and its row pulse land in the same slot. The expected change at each cross-point is therefore the stream length times the single-coincidence step times the two gained magnitudes.

The gain can be used in two ways. With rebalancing off, both vectors use the base gain as it is. With rebalancing on, the block first finds the largest magnitude in each vector. It then forms m = sqrt(row maximum / column maximum) with a sequential divider and a sequential square root. The column gain becomes C·m and the row gain becomes C/m. The product of the two gains stays the same, and the two sides fire at comparable rates. The base gain and the stream length are sampled at each start, so software can change them per layer without touching the pulse logic.

Elements are signed Q1.15 values. The base gain is an unsigned Q8.8 value. Each lane has its own 16-bit LFSR, and the lane fires when its random word lies below its probability word.

Top module: `stoch_pulse_gen`

## Requirements
- R1: Handshake. While idle, a high `start` latches both vectors, the stream length, the base gain and the rebalance enable. When the update ends, `done` rises and stays high as long as `start` stays high. `done` falls on the first clock edge at which `start` is low.
- R2: Stream length. An update with `stream_len` = L (1 to 255) produces exactly L cycles with `slot_valid` high. L = 0 produces no slot, and `done` follows.
- R3: Probability word. The probability word is p = floor(|x|·G / 128), where |x| is the magnitude of a Q1.15 element and G is a Q8.8 gain, so p has 16 fractional bits. A lane pulses in a slot exactly when its LFSR word is below p.
- R4: Saturation. When p is 65536 or more (a gained magnitude of 1.0 or more), the lane pulses in every slot.
- R5: A lane whose element is zero never pulses.
- R6: Random source. Lane k numbers the columns 0..N-1 and then the rows N..N+M-1. Its LFSR resets to 0xACE1 XOR (k·0x2F1B mod 2^16), or to 1 if that value is zero. Each step shifts the word right by one bit and XORs in 0xB400 when the bit shifted out was 1. The word steps once after each slot and keeps its value from one update to the next.
- R7: Each sign output equals bit 15 of the latched element and stays constant through the whole stream.
- R8: With rebalancing off, both column and row gains equal the base gain C.
- R9: With rebalancing on, m = floor(sqrt(floor(dmax·2^16 / xmax))) in Q8.8, raised to 1 if it is zero. The column gain is floor(C·m/256) and the row gain is floor(C·256/m).
- R10: If the largest column magnitude or the largest row magnitude is zero, no slot is issued and `done` asserts.
- R11: Changes on the vector, gain, length and enable inputs after the start has been accepted have no effect on the update in progress.
- R12: Outside a slot, all pulse outputs are low. `slot_valid` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Level request for an update |
| upd_mgmt_en | input | 1 | Enables gain rebalancing from the vector maxima |
| stream_len | input | BL_W | Number of slots per update |
| base_gain | input | 16 | Base gain C, unsigned Q8.8 |
| col_vec | input | 16·N_COL | Column elements, Q1.15, lane k at bits [16k+15:16k] |
| row_vec | input | 16·M_ROW | Row elements, Q1.15, lane k at bits [16k+15:16k] |
| slot_valid | output | 1 | High for one cycle per issued slot |
| col_pulse | output | N_COL | Column pulses for the current slot |
| col_sign | output | N_COL | Column sign bits |
| row_pulse | output | M_ROW | Row pulses for the current slot |
| row_sign | output | M_ROW | Row sign bits |
| done | output | 1 | Update finished; held while `start` stays high |

## Verification
The checker assumes that `start` is raised only after reset has been released. It also assumes that a start is followed by a wait for `done` before `start` is dropped. The slot-count bound relies on the stream length that was captured when the start was accepted, not on the live input. The bench always waits for `done` before releasing `start`. It changes the vectors and configuration in the middle of a stream only to show that these changes are ignored. It chooses magnitudes, maxima and gains that make every gained probability an exact binary fraction, so the expected values it computes with real arithmetic match the truncated fixed-point words exactly.

// File: rtl/spg_pkg.sv
package spg_pkg;

  localparam int ELEM_W = 16;   // Q1.15 element
  localparam int GAIN_W = 16;   // Q8.8 base gain
  localparam int EGAIN_W = 32;  // effective gain, Q24.8
  localparam int PROB_W = 17;   // probability word, bit 16 = "always"

  typedef enum logic [2:0] {
    S_IDLE, S_SCAN, S_DIVR, S_SQRT, S_DIVG, S_RUN, S_FIN, S_DONE
  } spg_state_e;

  function automatic logic [ELEM_W-1:0] mag_of(input logic [ELEM_W-1:0] v);
    return v[ELEM_W-1] ? (~v + 1'b1) : v;
  endfunction

  // Q1.15 magnitude times Q24.8 gain, truncated to 16 fractional bits, clipped at 1.0
  function automatic logic [PROB_W-1:0] gained_prob(input logic [ELEM_W-1:0] mag,
                                                    input logic [EGAIN_W-1:0] gain);
    logic [47:0] prod;
    logic [47:0] sh;
    prod = {32'd0, mag} * {16'd0, gain};
    sh = prod >> 7;
    if (sh >= 48'h10000) return 17'h10000;
    return sh[PROB_W-1:0];
  endfunction

  function automatic logic [15:0] lane_seed(input int k);
    logic [15:0] s;
    s = 16'hACE1 ^ 16'(k * 32'h2F1B);
    if (s == 16'h0) s = 16'h1;
    return s;
  endfunction

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

endpackage

// File: rtl/spg_divider.sv
module spg_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [W:0] shifted;
  logic [W:0] rem_sub;
  logic       ge;

  always_comb begin
    shifted = (rem_q << 1) | {{W{1'b0}}, quo_q[W-1]};
    ge      = shifted >= {1'b0, den_q};
    rem_sub = shifted - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0; quo_q <= num; den_q <= den;
        cnt_q <= CW'(W); busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? rem_sub : shifted;
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/spg_isqrt.sv
module spg_isqrt #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   radicand,
  output logic           done,
  output logic [W/2-1:0] root
);
  localparam int RW = W / 2;
  localparam int CW = $clog2(RW + 1);

  logic [W-1:0]  rad_q;
  logic [RW-1:0] root_q;
  logic [RW+2:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [RW+2:0] rem_sh;
  logic [RW+2:0] trial;
  logic [RW+2:0] rem_sub;
  logic          ge;

  always_comb begin
    rem_sh  = (rem_q << 2) | {{(RW+1){1'b0}}, rad_q[W-1:W-2]};
    trial   = {1'b0, root_q, 2'b01};
    ge      = rem_sh >= trial;
    rem_sub = rem_sh - trial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q <= '0; root_q <= '0; rem_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rad_q <= radicand; root_q <= '0; rem_q <= '0;
        cnt_q <= CW'(RW); busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge ? rem_sub : rem_sh;
        root_q <= {root_q[RW-2:0], ge};
        rad_q  <= rad_q << 2;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign root = root_q;
endmodule

// File: rtl/spg_lane.sv
module spg_lane
  import spg_pkg::*;
#(
  parameter int LANE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [PROB_W-1:0] prob,
  output logic              fire
);
  logic [15:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= lane_seed(LANE_ID);
    else if (adv) word_q <= lfsr_step(word_q);
  end

  assign fire = prob[PROB_W-1] | (word_q < prob[PROB_W-2:0]);
endmodule

// File: rtl/stoch_pulse_gen.sv
module stoch_pulse_gen
  import spg_pkg::*;
#(
  parameter int N_COL = 4,
  parameter int M_ROW = 3,
  parameter int BL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    upd_mgmt_en,
  input  logic [BL_W-1:0]         stream_len,
  input  logic [GAIN_W-1:0]       base_gain,
  input  logic [N_COL*ELEM_W-1:0] col_vec,
  input  logic [M_ROW*ELEM_W-1:0] row_vec,
  output logic                    slot_valid,
  output logic [N_COL-1:0]        col_pulse,
  output logic [N_COL-1:0]        col_sign,
  output logic [M_ROW-1:0]        row_pulse,
  output logic [M_ROW-1:0]        row_sign,
  output logic                    done
);
  localparam int LANES = N_COL + M_ROW;
  localparam int IDX_W = $clog2(LANES);

  spg_state_e state_q;
  logic [ELEM_W-1:0]  mag_q [LANES];
  logic [LANES-1:0]   sign_q;
  logic [BL_W-1:0]    bl_q;
  logic [BL_W-1:0]    slot_cnt_q;
  logic [GAIN_W-1:0]  gain_q;
  logic               um_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ELEM_W-1:0]  xmax_q, dmax_q;
  logic [31:0]        ratio_q;
  logic [15:0]        m_q;
  logic [EGAIN_W-1:0] cx_q, cy_q;
  logic               slot_valid_q;
  logic [LANES-1:0]   pulse_q;
  logic               div_go_q, sqrt_go_q;

  // named internal events
  logic accept, scan_last, zero_max_hit, lane_adv;
  logic [ELEM_W-1:0] elem [LANES];
  logic [ELEM_W-1:0] cur_mag, xmax_nx, dmax_nx;
  logic cur_is_col;
  logic [31:0] div_num, div_den, div_quo;
  logic        div_done, sqrt_done;
  logic [15:0] sqrt_root, m_clamp;
  logic [31:0] cx_full;
  logic [PROB_W-1:0] prob_w [LANES];
  logic [LANES-1:0]  fire_w;

  always_comb begin
    for (int k = 0; k < LANES; k++)
      elem[k] = (k < N_COL) ? col_vec[k*ELEM_W +: ELEM_W]
                            : row_vec[(k-N_COL)*ELEM_W +: ELEM_W];
  end

  assign accept       = (state_q == S_IDLE) && start;
  assign cur_mag      = mag_q[idx_q];
  assign cur_is_col   = int'(idx_q) < N_COL;
  assign xmax_nx      = (cur_is_col && cur_mag > xmax_q) ? cur_mag : xmax_q;
  assign dmax_nx      = (!cur_is_col && cur_mag > dmax_q) ? cur_mag : dmax_q;
  assign scan_last    = (state_q == S_SCAN) && (int'(idx_q) == LANES - 1);
  assign zero_max_hit = scan_last && (xmax_nx == '0 || dmax_nx == '0 || bl_q == '0);
  assign lane_adv     = (state_q == S_RUN);

  assign div_num = (state_q == S_DIVR) ? {dmax_q, 16'h0000} : {8'h00, gain_q, 8'h00};
  assign div_den = (state_q == S_DIVR) ? {16'h0000, xmax_q} : {16'h0000, m_q};
  assign m_clamp = (sqrt_root == 16'h0) ? 16'h1 : sqrt_root;
  assign cx_full = ({16'h0, gain_q} * {16'h0, m_clamp}) >> 8;

  spg_divider #(.W(32)) div_i (
    .clk(clk), .rst_n(rst_n), .go(div_go_q), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo)
  );

  spg_isqrt #(.W(32)) sqrt_i (
    .clk(clk), .rst_n(rst_n), .go(sqrt_go_q), .radicand(ratio_q),
    .done(sqrt_done), .root(sqrt_root)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign prob_w[k] = gained_prob(mag_q[k], (k < N_COL) ? cx_q : cy_q);
    spg_lane #(.LANE_ID(k)) lane_i (
      .clk(clk), .rst_n(rst_n), .adv(lane_adv), .prob(prob_w[k]), .fire(fire_w[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      for (int k = 0; k < LANES; k++) mag_q[k] <= '0;
      sign_q <= '0; bl_q <= '0; slot_cnt_q <= '0; gain_q <= '0; um_q <= 1'b0;
      idx_q <= '0; xmax_q <= '0; dmax_q <= '0; ratio_q <= '0; m_q <= 16'h1;
      cx_q <= '0; cy_q <= '0; slot_valid_q <= 1'b0; pulse_q <= '0;
      div_go_q <= 1'b0; sqrt_go_q <= 1'b0;
    end else begin
      div_go_q     <= 1'b0;
      sqrt_go_q    <= 1'b0;
      slot_valid_q <= 1'b0;
      pulse_q      <= '0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          for (int k = 0; k < LANES; k++) begin
            mag_q[k]  <= mag_of(elem[k]);
            sign_q[k] <= elem[k][ELEM_W-1];
          end
          bl_q <= stream_len; gain_q <= base_gain; um_q <= upd_mgmt_en;
          idx_q <= '0; xmax_q <= '0; dmax_q <= '0; slot_cnt_q <= '0;
          state_q <= S_SCAN;
        end
        S_SCAN: begin
          xmax_q <= xmax_nx;
          dmax_q <= dmax_nx;
          idx_q  <= idx_q + 1'b1;
          if (scan_last) begin
            if (zero_max_hit) state_q <= S_DONE;
            else if (um_q) begin
              div_go_q <= 1'b1;
              state_q  <= S_DIVR;
            end else begin
              cx_q <= {16'h0, gain_q};
              cy_q <= {16'h0, gain_q};
              state_q <= S_RUN;
            end
          end
        end
        S_DIVR: if (div_done) begin
          ratio_q   <= div_quo;
          sqrt_go_q <= 1'b1;
          state_q   <= S_SQRT;
        end
        S_SQRT: if (sqrt_done) begin
          m_q      <= m_clamp;
          cx_q     <= cx_full;
          div_go_q <= 1'b1;
          state_q  <= S_DIVG;
        end
        S_DIVG: if (div_done) begin
          cy_q    <= div_quo;
          state_q <= S_RUN;
        end
        S_RUN: begin
          slot_valid_q <= 1'b1;
          pulse_q      <= fire_w;
          slot_cnt_q   <= slot_cnt_q + 1'b1;
          if (slot_cnt_q == bl_q - 1'b1) state_q <= S_FIN;
        end
        S_FIN:  state_q <= S_DONE;
        S_DONE: if (!start) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign slot_valid = slot_valid_q;
  assign col_pulse  = pulse_q[N_COL-1:0];
  assign row_pulse  = pulse_q[LANES-1:N_COL];
  assign col_sign   = sign_q[N_COL-1:0];
  assign row_sign   = sign_q[LANES-1:N_COL];
  assign done       = (state_q == S_DONE);
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int N_COL = 4,
  parameter int M_ROW = 3,
  parameter int BL_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             slot_valid,
  input logic [N_COL-1:0] col_pulse,
  input logic [M_ROW-1:0] row_pulse,
  input logic [N_COL-1:0] col_sign,
  input logic [M_ROW-1:0] row_sign,
  input logic [BL_W-1:0]  bl_q,
  input logic             accept,
  input logic             zero_max_hit
);
  logic [BL_W:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         seen_q <= '0;
    else if (accept)                    seen_q <= '0;
    else if (slot_valid && !(&seen_q))  seen_q <= seen_q + 1'b1;
  end

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |-> (col_pulse == '0 && row_pulse == '0));

  // R12
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && slot_valid));

  // R1
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R1
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= {1'b0, bl_q});

  // R7
  sign_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && $past(slot_valid)) |-> ($stable(col_sign) && $stable(row_sign)));

  // R10
  zero_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_max_hit |=> (done && !slot_valid));
endmodule

bind stoch_pulse_gen spg_checker #(.N_COL(N_COL), .M_ROW(M_ROW), .BL_W(BL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .slot_valid(slot_valid),
  .col_pulse(col_pulse), .row_pulse(row_pulse), .col_sign(col_sign), .row_sign(row_sign),
  .bl_q(bl_q), .accept(accept), .zero_max_hit(zero_max_hit)
);

// File: tb/stoch_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module stoch_pulse_gen_tb_top;
  localparam int NC = 4;
  localparam int MR = 3;
  localparam int NL = NC + MR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic upd_mgmt_en = 1'b0;
  logic [7:0] stream_len = '0;
  logic [15:0] base_gain = '0;
  logic [NC*16-1:0] col_vec = '0;
  logic [MR*16-1:0] row_vec = '0;
  logic slot_valid, done;
  logic [NC-1:0] col_pulse, col_sign;
  logic [MR-1:0] row_pulse, row_sign;

  int checks = 0;
  int fails = 0;
  logic [15:0] lf [NL];

  always #10 clk = ~clk;

  stoch_pulse_gen #(.N_COL(NC), .M_ROW(MR), .BL_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .upd_mgmt_en(upd_mgmt_en),
    .stream_len(stream_len), .base_gain(base_gain), .col_vec(col_vec), .row_vec(row_vec),
    .slot_valid(slot_valid), .col_pulse(col_pulse), .col_sign(col_sign),
    .row_pulse(row_pulse), .row_sign(row_sign), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference random source, written from the requirement text (R6)
  function automatic logic [15:0] seed_of(input int k);
    logic [15:0] s;
    s = 16'hACE1 ^ 16'((k * 12059) & 16'hFFFF);
    return (s == 0) ? 16'd1 : s;
  endfunction

  function automatic logic [15:0] next_word(input logic [15:0] s);
    logic out_bit;
    out_bit = s[0];
    s = s >> 1;
    if (out_bit) s = s ^ 16'hB400;
    return s;
  endfunction

  // R3 R4: expected probability word from a real-valued gain
  function automatic int prob_of(input int mag, input real g);
    real p;
    p = (mag / 32768.0) * g;
    if (p >= 1.0) return 65536;
    return $rtoi(p * 65536.0);
  endfunction

  task automatic run_update(input bit um, input int bl, input int gain,
                            input logic [NC*16-1:0] cv, input logic [MR*16-1:0] rv,
                            input bit disturb, input string name);
    int mag [NL];
    int p [NL];
    int hits [NL];
    logic [15:0] e [NL];
    int xmax, dmax, slots, exp_slots, cyc;
    real gx, gy, m;
    logic [NL-1:0] exp_bits, exp_sign;
    xmax = 0; dmax = 0;
    for (int k = 0; k < NL; k++) begin
      e[k] = (k < NC) ? cv[k*16 +: 16] : rv[(k-NC)*16 +: 16];
      mag[k] = ($signed(e[k]) < 0) ? -int'($signed(e[k])) : int'($signed(e[k]));
      if (k < NC && mag[k] > xmax) xmax = mag[k];
      if (k >= NC && mag[k] > dmax) dmax = mag[k];
      exp_sign[k] = e[k][15];
      hits[k] = 0;
    end
    gx = gain / 256.0; gy = gx;
    if (um && xmax > 0 && dmax > 0) begin  // R9
      m = $sqrt(real'(dmax) / real'(xmax));
      gx = gx * m; gy = gy / m;
    end
    for (int k = 0; k < NL; k++) p[k] = prob_of(mag[k], (k < NC) ? gx : gy);
    exp_slots = (xmax == 0 || dmax == 0 || bl == 0) ? 0 : bl;

    @(negedge clk);
    upd_mgmt_en = um; stream_len = 8'(bl); base_gain = 16'(gain);
    col_vec = cv; row_vec = rv; start = 1'b1;
    slots = 0; cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (slot_valid) begin
        slots++;
        for (int k = 0; k < NL; k++) begin
          exp_bits[k] = (p[k] >= 65536) || (int'(lf[k]) < p[k]);
          lf[k] = next_word(lf[k]);
        end
        chk({row_pulse, col_pulse} == exp_bits, "R3 R4 R5 R6", {name, " slot pulses"},
            {row_pulse, col_pulse}, exp_bits);
        chk({row_sign, col_sign} == exp_sign, "R7", {name, " signs"},
            {row_sign, col_sign}, exp_sign);
        for (int k = 0; k < NL; k++) if (exp_bits[k]) hits[k]++;
        if (disturb && slots == 1) begin  // R11: late input changes
          col_vec = ~cv; row_vec = ~rv; base_gain = 16'hFFFF;
          stream_len = 8'd3; upd_mgmt_en = ~um;
        end
      end
    end
    chk(done === 1'b1, "R1", {name, " done reached"}, done, 1);
    chk(slots == exp_slots, (exp_slots == 0) ? "R10" : "R2", {name, " slot count"},
        slots, exp_slots);
    for (int k = 0; k < NL; k++) begin
      if (p[k] >= 65536) chk(hits[k] == slots, "R4", {name, " saturated lane"}, hits[k], slots);
      if (mag[k] == 0)   chk(hits[k] == 0, "R5", {name, " zero lane"}, hits[k], 0);
    end
    chk(slot_valid == 1'b0 && col_pulse == '0 && row_pulse == '0, "R12",
        {name, " quiet at done"}, {slot_valid, row_pulse, col_pulse}, 0);
    repeat (2) @(negedge clk);
    chk(done === 1'b1, "R1", {name, " done held"}, done, 1);
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R1", {name, " done released"}, done, 0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NL; k++) lf[k] = seed_of(k);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && slot_valid == 1'b0, "R1", "reset state", {done, slot_valid}, 0);
    chk(col_pulse == '0 && row_pulse == '0, "R12", "reset pulses", {row_pulse, col_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    // R8 R3 R4 R5: gain 1.0, ten slots, one saturated and one zero column
    run_update(1'b0, 10, 256, {16'hF000, 16'h0000, 16'h2000, 16'h8000},
               {16'h0800, 16'hE000, 16'h4000}, 1'b0, "R8 bl10");
    // R9: row max below column max, m = 0.5
    run_update(1'b1, 40, 256, {16'h0000, 16'h1000, 16'hE000, 16'h2000},
               {16'h0400, 16'hFC00, 16'h0800}, 1'b0, "R9 m_half");
    // R9 R11: row max above column max, m = 2.0, inputs disturbed mid-stream
    run_update(1'b1, 40, 256, {16'h0400, 16'h0000, 16'hFC00, 16'h0800},
               {16'hE000, 16'h1000, 16'h2000}, 1'b1, "R9 R11 m_two");
    // R2 R4: single slot with a gain of about 3.16
    run_update(1'b0, 1, 809, {16'h0000, 16'h0000, 16'h4000, 16'h2000},
               {16'h7FFF, 16'h0000, 16'h1000}, 1'b0, "R2 bl1");
    // R10: all rows zero
    run_update(1'b0, 10, 256, {16'h0000, 16'h1000, 16'hC000, 16'h2000},
               {16'h0000, 16'h0000, 16'h0000}, 1'b0, "R10 zero rows");
    // R2: zero length
    run_update(1'b0, 0, 256, {16'h0000, 16'h1000, 16'hC000, 16'h2000},
               {16'h0100, 16'h0000, 16'h0200}, 1'b0, "R2 bl0");
    // R6: long stream continues every lane's sequence
    run_update(1'b0, 255, 128, {16'h3000, 16'h9000, 16'h0800, 16'h6000},
               {16'h1800, 16'hA000, 16'h0200}, 1'b0, "R6 bl255");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule